// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Counter

This block keeps a 16-bit running count that stands in for the charge a battery loses through self-discharge while it sits idle. The count goes up with elapsed time, and its rate depends on the present cell temperature. It is one count per hour in the room-temperature band. The rate doubles for each 10 °C step above that band, up to sixteen counts per hour, and halves for each 10 °C step below it, down to one count per eight hours. The count never saturates: it rolls over from 0xFFFF to 0x0000. The host is expected to read it and clear it often enough to make sense of it.

Time comes in as a single-cycle tick at a fixed rate. The parameter `TICKS_PER_HOUR` gives the number of ticks in one hour. Each tick adds a band weight, in eighths of a count per hour, to a fractional-hour phase accumulator. When that accumulator reaches eight hours' worth of ticks, the counter steps once and the remainder is kept. The temperature is a signed whole-degree value that the block samples on each tick. A synchronous clear strobe zeroes both the count and the phase. The sleep indicator does not gate counting, because the count has to keep running through sleep.

Top module: `selfdis_counter`

## Requirements
- R1: After reset the count reads 0x0000 and the phase accumulator is empty.
- R2: With the temperature anywhere from 20 °C to 30 °C inclusive, the count advances one step per TICKS_PER_HOUR ticks.
- R3: Above 30 °C the rate is 2 counts/hour for (30,40], 4 for (40,50] and 8 for (50,60].
- R4: Above 60 °C the rate holds at 16 counts/hour, including at the largest representable temperature.
- R5: Below 20 °C the rate is 1/2 count/hour for [10,20) and 1/4 count/hour for [0,10).
- R6: Below 0 °C the rate holds at 1 count per 8 hours, including at the most negative representable temperature.
- R7: The count changes only on a cycle with the tick high. It changes by at most one per tick. The fractional remainder carries across ticks, including across temperature changes, so after N ticks the count equals the floor of the summed weights divided by 8×TICKS_PER_HOUR.
- R8: A step from 0xFFFF yields 0x0000, and counting continues from there.
- R9: Clear zeroes the count and the fractional phase in the next cycle. It wins over a tick in the same cycle.
- R10: The sleep input has no effect on counting. The same ticks and temperatures give the same count whether it is high or low.
- R11: The count is presented as a high byte (bits 15:8) and a low byte (bits 7:0) of one 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_tick | input | 1 | One-cycle time-base pulse, TICKS_PER_HOUR per hour |
| temp_c | input | TEMP_W | Signed temperature in whole degrees Celsius |
| clear | input | 1 | Synchronous clear of count and phase |
| sleep | input | 1 | Device sleep indicator; does not stop counting |
| count_hi | output | CNT_W/2 | Upper byte of the count |
| count_lo | output | CNT_W/2 | Lower byte of the count |

## Verification
The rollover from 0xFFFF is the hardest case to reach from the ports, because it needs 65,536 steps. The bench pins the temperature above 60 °C and uses a time base of sixteen ticks per hour, so that every tick is exactly one step. It then ticks without a break until just before the rollover, and on the way it checks the byte split at an intermediate value. A second hard case is the carried fraction, which shows up only as a missing or early step. Directed sequences clear part-way through an hour and change the temperature between ticks, and long random runs compare every cycle against a rate model in the bench.

// File: rtl/sdc_pkg.sv
// Shared constants for the self-discharge counter.
// Bands are numbered 0 (coldest) to 7 (hottest). Band k carries the weight
// 2**k in eighths of a count per hour, so band 3 is one count per hour.
package sdc_pkg;
    localparam int NUM_BANDS   = 8;
    localparam int BAND_W      = $clog2(NUM_BANDS);
    localparam int WEIGHT_W    = NUM_BANDS;     // holds 2**(NUM_BANDS-1)
    localparam int WEIGHT_UNIT = 8;             // weight steps per count per hour
    // Lowest temperature at which band k+1 applies.
    localparam int BAND_EDGE [NUM_BANDS-1] = '{0, 10, 20, 31, 41, 51, 61};
endpackage

// File: rtl/sdc_rate_sel.sv
// Maps a signed temperature to a phase weight.
// Assumes: temp_c is signed whole degrees. The band edges in the package
// ascend, so the number of edges passed gives the band index.
module sdc_rate_sel
    import sdc_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic signed [TEMP_W-1:0]   temp_c,
    output logic        [WEIGHT_W-1:0] weight
);
    logic [NUM_BANDS-2:0] above;
    logic [BAND_W-1:0]    band;

    // One comparator per band edge.
    for (genvar k = 0; k < NUM_BANDS - 1; k++) begin : g_edge
        assign above[k] = (temp_c >= BAND_EDGE[k]);
    end

    // Band index is the number of edges the temperature has reached.
    always_comb begin
        band   = BAND_W'($countones(above));
        weight = WEIGHT_W'(1) << band;
    end
endmodule

// File: rtl/sdc_phase_acc.sv
// Fractional-hour phase accumulator. On each tick it adds the band weight
// and asks for one step when the sum reaches THR, keeping the remainder.
// Assumes THR >= 2**(WEIGHT_W-1), so one tick produces at most one step.
module sdc_phase_acc
    import sdc_pkg::*;
#(
    parameter int THR   = 128,
    parameter int ACC_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                clear,
    input  logic [WEIGHT_W-1:0] weight,
    output logic                step,
    output logic [ACC_W-1:0]    acc_q
);
    localparam logic [ACC_W:0] THR_V = (ACC_W+1)'(THR);

    logic [ACC_W:0] sum;

    // Next phase and step request for this tick.
    always_comb begin
        sum  = {1'b0, acc_q} + (ACC_W+1)'(weight);
        step = tick && !clear && (sum >= THR_V);
    end

    // Phase register: clear first, then accumulate on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= step ? ACC_W'(sum - THR_V) : ACC_W'(sum);
        end
    end
endmodule

// File: rtl/sdc_wrap_counter.sv
// Free-running up counter that rolls over at full scale.
// Assumes the caller has already given clear priority over inc.
module sdc_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clear,
    output logic [CNT_W-1:0] count_q
);
    // Count register: zero on reset or clear, step on inc.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/selfdis_counter.sv
// Temperature-scaled self-discharge counter (top level).
// Picks a rate band from temp_c, accumulates fractional hours on each
// time_tick and steps a rolling 16-bit count. Sleep does not stop counting.
// Assumes: TICKS_PER_HOUR >= 16 and CNT_W is even.
module selfdis_counter
    import sdc_pkg::*;
#(
    parameter int TICKS_PER_HOUR = 3600,
    parameter int TEMP_W         = 8,
    parameter int CNT_W          = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    time_tick,
    input  logic signed [TEMP_W-1:0] temp_c,
    input  logic                    clear,
    input  logic                    sleep,
    output logic [CNT_W/2-1:0]      count_hi,
    output logic [CNT_W/2-1:0]      count_lo
);
    localparam int THR    = WEIGHT_UNIT * TICKS_PER_HOUR;
    localparam int ACC_W  = $clog2(THR);
    localparam int HALF_W = CNT_W / 2;

    logic [WEIGHT_W-1:0] weight;
    logic                step;
    logic [ACC_W-1:0]    phase_q;
    logic [CNT_W-1:0]    count_q;
    logic                unused_sleep;

    // Sleep is accepted but has no effect: counting continues in sleep.
    assign unused_sleep = sleep;

    sdc_rate_sel #(.TEMP_W(TEMP_W)) u_rate (
        .temp_c (temp_c),
        .weight (weight)
    );

    sdc_phase_acc #(.THR(THR), .ACC_W(ACC_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (time_tick),
        .clear  (clear),
        .weight (weight),
        .step   (step),
        .acc_q  (phase_q)
    );

    sdc_wrap_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (step),
        .clear   (clear),
        .count_q (count_q)
    );

    // Byte split of the count.
    assign count_hi = count_q[CNT_W-1:HALF_W];
    assign count_lo = count_q[HALF_W-1:0];
endmodule

// File: rtl/sdc_checker.sv
// Temporal checks for selfdis_counter, attached by bind.
module sdc_checker #(
    parameter int THR   = 128,
    parameter int ACC_W = 7,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 time_tick,
    input logic                 clear,
    input logic [CNT_W/2-1:0]   count_hi,
    input logic [CNT_W/2-1:0]   count_lo,
    input logic [ACC_W-1:0]     phase_q
);
    logic [CNT_W-1:0] cnt;
    assign cnt = {count_hi, count_lo};

    // R9: clear empties count and phase, whatever the tick does
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0) && (phase_q == '0));

    // R7: without a tick nothing moves
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_tick && !clear) |=> ($stable(cnt) && $stable(phase_q)));

    // R7: a tick moves the count by zero or one
    p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (time_tick && !clear) |=> ($stable(cnt) || (cnt == CNT_W'($past(cnt) + CNT_W'(1)))));

    // R7: the carried fraction stays below one step
    p_phase_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(phase_q) < THR);

    // R8: full scale steps to zero
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (time_tick && !clear && (cnt == '1)) |=> ((cnt == '0) || (cnt == '1)));
endmodule

bind selfdis_counter sdc_checker #(.THR(THR), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_sdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_tick (time_tick),
    .clear     (clear),
    .count_hi  (count_hi),
    .count_lo  (count_lo),
    .phase_q   (phase_q)
);

// File: tb/test_selfdis_counter.sv
module test_selfdis_counter;
    localparam int TPH = 16;
    localparam int THR = 8 * TPH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              time_tick = 1'b0;
    logic signed [7:0] temp_c = '0;
    logic              clear = 1'b0;
    logic              sleep = 1'b0;
    logic [7:0]        count_hi, count_lo;

    int n_chk = 0;
    int n_err = 0;
    int m_cnt = 0;
    int m_acc = 0;

    always #10 clk = ~clk;   // 50 MHz

    selfdis_counter #(.TICKS_PER_HOUR(TPH), .TEMP_W(8), .CNT_W(16)) i_selfdis_counter (
        .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .temp_c(temp_c),
        .clear(clear), .sleep(sleep), .count_hi(count_hi), .count_lo(count_lo)
    );

    // Rate in eighths of a count per hour, from the band table.
    function automatic int exp_weight(input int t);
        if (t < 0)        return 1;
        else if (t < 10)  return 2;
        else if (t < 20)  return 4;
        else if (t <= 30) return 8;
        else if (t <= 40) return 16;
        else if (t <= 50) return 32;
        else if (t <= 60) return 64;
        else              return 128;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, optionally compare at next negedge.
    task automatic cyc(input bit tk, input int t, input bit clr, input bit slp,
                       input bit do_chk, input string req);
        time_tick = tk;
        temp_c    = 8'(t);
        clear     = clr;
        sleep     = slp;
        @(posedge clk);
        if (clr) begin
            m_cnt = 0;
            m_acc = 0;
        end else if (tk) begin
            m_acc += exp_weight(t);
            if (m_acc >= THR) begin
                m_acc -= THR;
                m_cnt = (m_cnt + 1) & 16'hFFFF;
            end
        end
        @(negedge clk);
        time_tick = 1'b0;
        clear     = 1'b0;
        if (do_chk) check(req, int'({count_hi, count_lo}), m_cnt);
    endtask

    // Clear, run 256 ticks at one temperature, expect (256*weight)/THR steps.
    task automatic band_run(input int t, input string req);
        cyc(0, t, 1, 0, 0, req);
        for (int i = 0; i < 256; i++) cyc(1, t, 0, 0, 0, req);
        check(req, int'({count_hi, count_lo}), (256 * exp_weight(t)) / THR);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20190));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", int'({count_hi, count_lo}), 0);

        // R1: first step needs a full hour at 25 C, so phase started empty
        for (int i = 0; i < 15; i++) cyc(1, 25, 0, 0, 0, "R1");
        check("R1 phase empty", int'({count_hi, count_lo}), 0);
        cyc(1, 25, 0, 0, 1, "R1 first step");

        // R2 band edges of the room band
        band_run(20, "R2 20C");
        band_run(30, "R2 30C");
        // R3 warmer bands and their edges
        band_run(31, "R3 31C");
        band_run(40, "R3 40C");
        band_run(41, "R3 41C");
        band_run(50, "R3 50C");
        band_run(51, "R3 51C");
        band_run(60, "R3 60C");
        // R4 hottest band
        band_run(61, "R4 61C");
        band_run(127, "R4 127C");
        // R5 cooler bands
        band_run(19, "R5 19C");
        band_run(10, "R5 10C");
        band_run(9, "R5 9C");
        band_run(0, "R5 0C");
        // R6 coldest band
        band_run(-1, "R6 -1C");
        band_run(-128, "R6 -128C");

        // R7 fraction carries across a temperature change
        cyc(0, 25, 1, 0, 0, "R7");
        for (int i = 0; i < 12; i++) cyc(1, 25, 0, 0, 0, "R7");
        check("R7 before carry", int'({count_hi, count_lo}), 0);
        cyc(1, 45, 0, 0, 1, "R7 carried step");
        cyc(0, 45, 0, 0, 1, "R7 no tick hold");

        // R9 clear wins over tick, and clears the phase
        for (int i = 0; i < 5; i++) cyc(1, 70, 0, 0, 0, "R9");
        cyc(1, 70, 1, 0, 1, "R9 clear priority");
        for (int i = 0; i < 10; i++) cyc(1, 25, 0, 0, 0, "R9");
        cyc(0, 25, 1, 0, 0, "R9");
        for (int i = 0; i < 10; i++) cyc(1, 25, 0, 0, 0, "R9");
        check("R9 phase cleared", int'({count_hi, count_lo}), 0);

        // R10 sleep high changes nothing
        cyc(0, 45, 1, 0, 0, "R10");
        for (int i = 0; i < 40; i++) cyc(1, 45, 0, 1, 0, "R10");
        check("R10 sleep counting", int'({count_hi, count_lo}), 10);

        // R7 random mix against the model, checked every cycle
        for (int i = 0; i < 3000; i++) begin
            int t;
            t = int'($urandom_range(255)) - 128;
            cyc(1'($urandom_range(1)), t, ($urandom_range(99) == 0), 1'($urandom_range(1)),
                1, "R7 random");
        end

        // R11 and R8: one step per tick above 60 C
        cyc(0, 70, 1, 0, 0, "R11");
        for (int i = 0; i < 16'h12AB; i++) cyc(1, 70, 0, 0, 0, "R11");
        check("R11 high byte", int'(count_hi), 8'h12);
        check("R11 low byte", int'(count_lo), 8'hAB);
        for (int i = 16'h12AB; i < 16'hFFFF; i++) cyc(1, 70, 0, 0, 0, "R8");
        check("R8 full scale", int'({count_hi, count_lo}), 16'hFFFF);
        cyc(1, 70, 0, 0, 1, "R8 wrap to zero");
        cyc(1, 70, 0, 0, 1, "R8 count after wrap");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule